// File: doc/BRIEF.md
# Filter Output Buffer Controller

This block is the single-word output stage of a decimating digital filter. A result reaches it from the filter core when a decimation period ends. When the filter is bypassed, the result is a word taken straight from the input side instead. The stored word goes to one of two places. The first is an external result FIFO, fed through a valid/ready push. The second is a register that a host CPU or a DMA engine reads.

The block keeps the full/empty state of the buffer. What counts as "empty" depends on the destination. The block also sets a data-ready flag and raises either a DMA request or a level interrupt. It detects output overruns, and input overruns in the held-bypass path. Results produced while the filter is prefilling are suppressed. A soft-reset pulse flushes the buffer and cancels any pending transfer.

Top module: `fobuf_ctrl`

## Requirements
- R1: A result that is loaded (a filter result with `flt_valid` high, prefill low and bypass low) appears on `host_data`/`fifo_data` and sets `rdy_flag` one clock after the load cycle. This holds for both destinations (`dest_host` 0 = result FIFO, 1 = host register). After reset all outputs are 0.
- R2: While `prefill` is high and bypass is low, filter results are dropped. The buffer, `rdy_flag` and `ovr_flag` are left unchanged.
- R3: With the FIFO destination, `fifo_valid` is high exactly while the buffer is full. The buffer is empty in the cycle after a cycle in which `fifo_valid` and `fifo_ready` are both high.
- R4: With the host destination, the buffer becomes empty only when two things have happened: a read strobe `host_rd` was seen while it was full, and `rdy_flag` has been cleared. It is empty from the cycle after the later of the two.
- R5: A load into a full buffer that is not emptying in that same cycle overwrites the data and sets the sticky `ovr_flag`. Writing 1 on `clr_ovr` clears the flag. A new overrun in the same cycle takes precedence over the clear.
- R6: With the host destination and `dma_sel` high, a load raises `dma_req`. A `dma_ack` pulse clears it, and so does a `clr_rdy` pulse. `irq` is the level (`rdy_flag` AND `dest_host` AND `buf_ie` AND NOT `dma_sel`) OR (`err_en` AND (`ovr_flag` OR `iovr_flag`)). So when DMA is selected, a buffer update never raises the interrupt.
- R7: In bypass with the host destination, an `in_valid` word is loaded at once, just as in R1. If the buffer is still unemptied, this is an overrun by R5.
- R8: In bypass with the FIFO destination, an input word loads directly if the buffer is empty. Otherwise it is held in a one-word input holding register. The held word moves into the buffer in a cycle that starts with the buffer empty. An input word arriving while the buffer is full and the holding register is occupied is dropped, and it sets the sticky `iovr_flag`, which `clr_iovr` clears.
- R9: A `soft_rst` pulse empties the buffer and the holding register, zeroes the buffer data, clears `rdy_flag` and `dma_req`, and blocks any load in that cycle. The sticky overrun flags are left alone.
- R10: `clr_rdy` clears `rdy_flag`. If a load happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft reset pulse |
| bypass | input | 1 | Filter bypassed: source is the input word |
| dest_host | input | 1 | 0 = result FIFO, 1 = host register |
| prefill | input | 1 | Filter in prefill, results suppressed |
| dma_sel | input | 1 | Request DMA on host-destination updates |
| buf_ie | input | 1 | Buffer-update interrupt enable |
| err_en | input | 1 | Overrun interrupt enable |
| flt_valid | input | 1 | Filter result at decimation point |
| flt_data | input | DW | Filter result |
| in_valid | input | 1 | Bypass input word strobe |
| in_data | input | DW | Bypass input word |
| fifo_valid | output | 1 | Push valid to result FIFO |
| fifo_data | output | DW | Push data to result FIFO |
| fifo_ready | input | 1 | Result FIFO accepts |
| host_rd | input | 1 | One-cycle host read strobe of buffer |
| host_data | output | DW | Buffer contents for the host |
| clr_rdy | input | 1 | Write-one-to-clear data-ready |
| clr_ovr | input | 1 | Write-one-to-clear output overrun |
| clr_iovr | input | 1 | Write-one-to-clear input overrun |
| dma_ack | input | 1 | DMA acknowledge |
| rdy_flag | output | 1 | Output data ready |
| ovr_flag | output | 1 | Sticky output overrun |
| iovr_flag | output | 1 | Sticky input overrun |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Level interrupt |

## Verification
Directed sequences drive the main paths:
- a blocked FIFO push followed by a drain, which separates R3's one-cycle empty timing from a stuck valid;
- a host read done without the flag clear, which must still overrun, and then read plus clear, which must not — this distinguishes R4's two-condition emptiness from a read-only empty;
- three bypass words against a stalled FIFO, which exposes the hold, drop and release ordering of R8.

Constrained random traffic then mixes destinations, bypass, prefill and all the strobes, often landing in the same cycle. This tests the precedence rules (load over clear, emptying versus overrun, soft reset over everything) against a cycle model in the bench.

// File: rtl/fobuf_pkg.sv
package fobuf_pkg;
   typedef enum logic {
      DEST_FIFO = 1'b0,
      DEST_HOST = 1'b1
   } dest_e;

   localparam int unsigned FOBUF_MAX_DW = 64;
endpackage

// File: rtl/fobuf_src.sv
module fobuf_src
   import fobuf_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          bypass,
   input  dest_e         dest,
   input  logic          prefill,
   input  logic          flt_valid,
   input  logic [DW-1:0] flt_data,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          ob_full,
   output logic          load,
   output logic [DW-1:0] load_data,
   output logic          iovr_evt,
   output logic          hold_full
);
   logic [DW-1:0] hold_q, hold_d;
   logic          hold_full_d;

   always_comb begin
      load        = 1'b0;
      load_data   = flt_data;
      iovr_evt    = 1'b0;
      hold_full_d = hold_full;
      hold_d      = hold_q;
      if (!bypass) begin
         load      = flt_valid & ~prefill;
         load_data = flt_data;
      end else if (dest == DEST_HOST) begin
         load      = in_valid;
         load_data = in_data;
      end else if (hold_full) begin
         if (!ob_full) begin
            load        = 1'b1;
            load_data   = hold_q;
            hold_full_d = in_valid;
            if (in_valid) hold_d = in_data;
         end else if (in_valid) begin
            iovr_evt = 1'b1;
         end
      end else if (in_valid) begin
         if (!ob_full) begin
            load      = 1'b1;
            load_data = in_data;
         end else begin
            hold_full_d = 1'b1;
            hold_d      = in_data;
         end
      end
      if (soft_rst) begin
         load        = 1'b0;
         iovr_evt    = 1'b0;
         hold_full_d = 1'b0;
         hold_d      = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_q    <= '0;
      end else begin
         hold_full <= hold_full_d;
         hold_q    <= hold_d;
      end
   end

   // R2
   prefill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && prefill) |-> !load);
endmodule

// File: rtl/fobuf_store.sv
module fobuf_store
   import fobuf_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  dest_e         dest,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   input  logic          fifo_ready,
   input  logic          host_rd,
   input  logic          clr_rdy,
   output logic          ob_full,
   output logic [DW-1:0] ob_data,
   output logic          rdy_flag,
   output logic          ovr_evt
);
   logic rd_seen;
   logic push_done, host_empty, empty_now;

   assign push_done  = ob_full & (dest == DEST_FIFO) & fifo_ready;
   assign host_empty = ob_full & (dest == DEST_HOST) & (rd_seen | host_rd)
                       & (~rdy_flag | clr_rdy);
   assign empty_now  = push_done | host_empty;
   assign ovr_evt    = load & ob_full & ~empty_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ob_full  <= 1'b0;
         ob_data  <= '0;
         rdy_flag <= 1'b0;
         rd_seen  <= 1'b0;
      end else if (soft_rst) begin
         ob_full  <= 1'b0;
         ob_data  <= '0;
         rdy_flag <= 1'b0;
         rd_seen  <= 1'b0;
      end else if (load) begin
         ob_full  <= 1'b1;
         ob_data  <= load_data;
         rdy_flag <= 1'b1;
         rd_seen  <= 1'b0;
      end else begin
         if (empty_now)         ob_full  <= 1'b0;
         if (clr_rdy)           rdy_flag <= 1'b0;
         if (host_rd && ob_full) rd_seen <= 1'b1;
      end
   end

   // R3
   fifo_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_done && !load && !soft_rst) |=> !ob_full);
   // R1
   load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !soft_rst) |=> (ob_full && rdy_flag));
   // R10
   rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rdy && !load) |=> !rdy_flag);
endmodule

// File: rtl/fobuf_irq.sv
module fobuf_irq
   import fobuf_pkg::*;
#(
   parameter bit IRQ_FLOP = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  soft_rst,
   input  dest_e dest,
   input  logic  dma_sel,
   input  logic  buf_ie,
   input  logic  err_en,
   input  logic  load,
   input  logic  ovr_evt,
   input  logic  iovr_evt,
   input  logic  clr_ovr,
   input  logic  clr_iovr,
   input  logic  clr_rdy,
   input  logic  dma_ack,
   input  logic  rdy_flag,
   output logic  ovr_flag,
   output logic  iovr_flag,
   output logic  dma_req,
   output logic  irq
);
   logic irq_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_flag  <= 1'b0;
         iovr_flag <= 1'b0;
      end else begin
         if (ovr_evt)       ovr_flag  <= 1'b1;
         else if (clr_ovr)  ovr_flag  <= 1'b0;
         if (iovr_evt)      iovr_flag <= 1'b1;
         else if (clr_iovr) iovr_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      dma_req <= 1'b0;
      else if (soft_rst)                               dma_req <= 1'b0;
      else if (load && dest == DEST_HOST && dma_sel)   dma_req <= 1'b1;
      else if (dma_ack || clr_rdy)                     dma_req <= 1'b0;
   end

   assign irq_c = (rdy_flag & (dest == DEST_HOST) & buf_ie & ~dma_sel)
                | (err_en & (ovr_flag | iovr_flag));

   generate
      if (IRQ_FLOP) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_c;
         end
      end else begin : g_irq_comb
         assign irq = irq_c;
      end
   endgenerate

   // R5
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !clr_ovr) |=> ovr_flag);
   // R6
   dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && dma_ack && !load) |=> !dma_req);
endmodule

// File: rtl/fobuf_ctrl.sv
module fobuf_ctrl
   import fobuf_pkg::*;
#(
   parameter int unsigned DW       = 16,
   parameter bit          IRQ_FLOP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          bypass,
   input  logic          dest_host,
   input  logic          prefill,
   input  logic          dma_sel,
   input  logic          buf_ie,
   input  logic          err_en,
   input  logic          flt_valid,
   input  logic [DW-1:0] flt_data,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   output logic          fifo_valid,
   output logic [DW-1:0] fifo_data,
   input  logic          fifo_ready,
   input  logic          host_rd,
   output logic [DW-1:0] host_data,
   input  logic          clr_rdy,
   input  logic          clr_ovr,
   input  logic          clr_iovr,
   input  logic          dma_ack,
   output logic          rdy_flag,
   output logic          ovr_flag,
   output logic          iovr_flag,
   output logic          dma_req,
   output logic          irq
);
   generate
      if (DW < 1 || DW > FOBUF_MAX_DW) begin : g_bad_dw
         $error("fobuf_ctrl: DW out of range");
      end
   endgenerate

   dest_e         dest;
   logic          load, iovr_evt, ovr_evt, hold_full, ob_full;
   logic [DW-1:0] load_data, ob_data;

   assign dest = dest_host ? DEST_HOST : DEST_FIFO;

   fobuf_src #(.DW(DW)) u_src (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bypass(bypass),
      .dest(dest), .prefill(prefill), .flt_valid(flt_valid),
      .flt_data(flt_data), .in_valid(in_valid), .in_data(in_data),
      .ob_full(ob_full), .load(load), .load_data(load_data),
      .iovr_evt(iovr_evt), .hold_full(hold_full)
   );

   fobuf_store #(.DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dest(dest),
      .load(load), .load_data(load_data), .fifo_ready(fifo_ready),
      .host_rd(host_rd), .clr_rdy(clr_rdy), .ob_full(ob_full),
      .ob_data(ob_data), .rdy_flag(rdy_flag), .ovr_evt(ovr_evt)
   );

   fobuf_irq #(.IRQ_FLOP(IRQ_FLOP)) u_irq (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dest(dest),
      .dma_sel(dma_sel), .buf_ie(buf_ie), .err_en(err_en), .load(load),
      .ovr_evt(ovr_evt), .iovr_evt(iovr_evt), .clr_ovr(clr_ovr),
      .clr_iovr(clr_iovr), .clr_rdy(clr_rdy), .dma_ack(dma_ack),
      .rdy_flag(rdy_flag), .ovr_flag(ovr_flag), .iovr_flag(iovr_flag),
      .dma_req(dma_req), .irq(irq)
   );

   assign fifo_valid = ob_full & (dest == DEST_FIFO);
   assign fifo_data  = ob_data;
   assign host_data  = ob_data;

   // R8
   in_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && !dest_host && hold_full && ob_full && in_valid && !soft_rst)
      |=> iovr_flag);
   // R9
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!ob_full && !rdy_flag && !dma_req && !hold_full));
   // R6
   dma_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_sel && !ovr_flag && !iovr_flag) |-> !(IRQ_FLOP == 1'b0 && irq));
endmodule

// File: tb/sim_fobuf_ctrl.sv
module sim_fobuf_ctrl;
   localparam int DW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic soft_rst, bypass, dest_host, prefill, dma_sel, buf_ie, err_en;
   logic flt_valid, in_valid, fifo_ready, host_rd, clr_rdy, clr_ovr, clr_iovr, dma_ack;
   logic [DW-1:0] flt_data, in_data;
   logic fifo_valid, rdy_flag, ovr_flag, iovr_flag, dma_req, irq;
   logic [DW-1:0] fifo_data, host_data;

   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state
   bit m_full, m_rdy, m_rd, m_ovr, m_iovr, m_ibf, m_dma;
   logic [DW-1:0] m_data, m_ibd;

   always #5 clk = ~clk;

   fobuf_ctrl #(.DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bypass(bypass),
      .dest_host(dest_host), .prefill(prefill), .dma_sel(dma_sel),
      .buf_ie(buf_ie), .err_en(err_en), .flt_valid(flt_valid),
      .flt_data(flt_data), .in_valid(in_valid), .in_data(in_data),
      .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
      .host_rd(host_rd), .host_data(host_data), .clr_rdy(clr_rdy),
      .clr_ovr(clr_ovr), .clr_iovr(clr_iovr), .dma_ack(dma_ack),
      .rdy_flag(rdy_flag), .ovr_flag(ovr_flag), .iovr_flag(iovr_flag),
      .dma_req(dma_req), .irq(irq)
   );

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit exp_irq();
      return (m_rdy && dest_host && buf_ie && !dma_sel) || (err_en && (m_ovr || m_iovr));
   endfunction

   task automatic strobes_off();
      soft_rst = 0; flt_valid = 0; in_valid = 0; host_rd = 0;
      clr_rdy = 0; clr_ovr = 0; clr_iovr = 0; dma_ack = 0;
   endtask

   // One clock: compute expected next state from the requirements, step, compare.
   task automatic cyc();
      bit ld = 0, iev = 0, nibf = m_ibf, push, hemp, oev;
      logic [DW-1:0] ldd = flt_data, nibd = m_ibd;
      if (!bypass) begin ld = flt_valid && !prefill; ldd = flt_data; end           // R1 R2
      else if (dest_host) begin ld = in_valid; ldd = in_data; end                  // R7
      else if (m_ibf) begin                                                        // R8
         if (!m_full) begin ld = 1; ldd = m_ibd; nibf = in_valid; if (in_valid) nibd = in_data; end
         else if (in_valid) iev = 1;
      end else if (in_valid) begin
         if (!m_full) begin ld = 1; ldd = in_data; end
         else begin nibf = 1; nibd = in_data; end
      end
      if (soft_rst) begin ld = 0; iev = 0; nibf = 0; nibd = '0; end
      push = m_full && !dest_host && fifo_ready;
      hemp = m_full && dest_host && (m_rd || host_rd) && (!m_rdy || clr_rdy);
      oev  = ld && m_full && !(push || hemp);
      @(posedge clk); #1;
      if (oev) m_ovr = 1; else if (clr_ovr) m_ovr = 0;
      if (iev) m_iovr = 1; else if (clr_iovr) m_iovr = 0;
      if (soft_rst) m_dma = 0;
      else if (ld && dest_host && dma_sel) m_dma = 1;
      else if (dma_ack || clr_rdy) m_dma = 0;
      if (soft_rst) begin m_full = 0; m_data = '0; m_rdy = 0; m_rd = 0; end
      else if (ld) begin m_full = 1; m_data = ldd; m_rdy = 1; m_rd = 0; end
      else begin
         if (push || hemp) m_full = 0;
         if (clr_rdy) m_rdy = 0;
         if (host_rd && m_full) m_rd = 1;
      end
      m_ibf = nibf; m_ibd = nibd;
      check("R3 fifo_valid", {15'd0, fifo_valid}, {15'd0, m_full && !dest_host});
      check("R1 data", host_data, m_data);
      check("R1 fifo_data", fifo_data, m_data);
      check("R10 rdy_flag", {15'd0, rdy_flag}, {15'd0, m_rdy});
      check("R5 ovr_flag", {15'd0, ovr_flag}, {15'd0, m_ovr});
      check("R8 iovr_flag", {15'd0, iovr_flag}, {15'd0, m_iovr});
      check("R6 dma_req", {15'd0, dma_req}, {15'd0, m_dma});
      check("R6 irq", {15'd0, irq}, {15'd0, exp_irq()});
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      strobes_off();
      bypass = 0; dest_host = 0; prefill = 0; dma_sel = 0; buf_ie = 0; err_en = 0;
      fifo_ready = 0; flt_data = '0; in_data = '0;
      {m_full, m_rdy, m_rd, m_ovr, m_iovr, m_ibf, m_dma} = '0;
      m_data = '0; m_ibd = '0;
      repeat (3) @(posedge clk);
      #1;
      // reset state (R1)
      check("R1 reset fifo_valid", {15'd0, fifo_valid}, 16'd0);
      check("R1 reset data", host_data, 16'd0);
      check("R1 reset flags", {11'd0, rdy_flag, ovr_flag, iovr_flag, dma_req, irq}, 16'd0);
      rst_n = 1;
      @(posedge clk); #1;

      // R1 R3: FIFO destination, blocked then drained
      flt_valid = 1; flt_data = 16'hA1A1; cyc(); strobes_off();
      check("R1 load data", fifo_data, 16'hA1A1);
      check("R3 valid while full", {15'd0, fifo_valid}, 16'd1);
      cyc();
      check("R3 valid held", {15'd0, fifo_valid}, 16'd1);
      fifo_ready = 1; cyc(); fifo_ready = 0;
      check("R3 empty after push", {15'd0, fifo_valid}, 16'd0);
      clr_rdy = 1; cyc(); strobes_off();

      // R2 prefill suppression
      prefill = 1; flt_valid = 1; flt_data = 16'hBEEF; cyc(); strobes_off(); prefill = 0;
      check("R2 no flag in prefill", {15'd0, rdy_flag}, 16'd0);
      check("R2 no load in prefill", {15'd0, fifo_valid}, 16'd0);

      // R5 overrun
      flt_valid = 1; flt_data = 16'h1111; cyc();
      flt_data = 16'h2222; cyc(); strobes_off();
      check("R5 overrun set", {15'd0, ovr_flag}, 16'd1);
      check("R5 overwritten", fifo_data, 16'h2222);
      clr_ovr = 1; cyc(); strobes_off();
      check("R5 overrun cleared", {15'd0, ovr_flag}, 16'd0);
      fifo_ready = 1; clr_rdy = 1; cyc(); strobes_off(); fifo_ready = 0;

      // R4 host destination emptiness
      dest_host = 1;
      flt_valid = 1; flt_data = 16'h3333; cyc(); strobes_off();
      host_rd = 1; cyc(); strobes_off();
      flt_valid = 1; flt_data = 16'h4444; cyc(); strobes_off();
      check("R4 read alone not empty", {15'd0, ovr_flag}, 16'd1);
      clr_ovr = 1; cyc(); strobes_off();
      host_rd = 1; cyc(); strobes_off();
      clr_rdy = 1; cyc(); strobes_off();
      flt_valid = 1; flt_data = 16'h5555; cyc(); strobes_off();
      check("R4 read and clear empties", {15'd0, ovr_flag}, 16'd0);
      check("R4 host data", host_data, 16'h5555);

      // R10 clear and load in one cycle
      clr_rdy = 1; host_rd = 1; flt_valid = 1; flt_data = 16'h6666; cyc(); strobes_off();
      check("R10 set wins", {15'd0, rdy_flag}, 16'd1);
      host_rd = 1; cyc(); strobes_off(); clr_rdy = 1; cyc(); strobes_off();

      // R6 DMA priority and interrupt
      dma_sel = 1; buf_ie = 1;
      flt_valid = 1; flt_data = 16'h7777; cyc(); strobes_off();
      check("R6 dma raised", {15'd0, dma_req}, 16'd1);
      check("R6 no irq with dma", {15'd0, irq}, 16'd0);
      dma_ack = 1; cyc(); strobes_off();
      check("R6 dma acked", {15'd0, dma_req}, 16'd0);
      dma_sel = 0; cyc();
      check("R6 irq level", {15'd0, irq}, 16'd1);
      host_rd = 1; cyc(); strobes_off(); clr_rdy = 1; cyc(); strobes_off();
      check("R6 irq drops", {15'd0, irq}, 16'd0);
      buf_ie = 0;

      // R7 bypass to host register
      bypass = 1; in_valid = 1; in_data = 16'h8888; cyc(); strobes_off();
      check("R7 immediate", host_data, 16'h8888);
      check("R7 flag", {15'd0, rdy_flag}, 16'd1);
      host_rd = 1; cyc(); strobes_off(); clr_rdy = 1; cyc(); strobes_off();

      // R8 bypass to FIFO with hold
      dest_host = 0;
      in_valid = 1; in_data = 16'h0001; cyc();
      in_data = 16'h0002; cyc();
      check("R8 held not moved", fifo_data, 16'h0001);
      check("R8 no iovr yet", {15'd0, iovr_flag}, 16'd0);
      in_data = 16'h0003; cyc(); strobes_off();
      check("R8 input overrun", {15'd0, iovr_flag}, 16'd1);
      fifo_ready = 1; cyc(); fifo_ready = 0;
      check("R8 drained", {15'd0, fifo_valid}, 16'd0);
      cyc();
      check("R8 hold released", fifo_data, 16'h0002);
      err_en = 1; cyc();
      check("R6 irq on overrun", {15'd0, irq}, 16'd1);
      clr_iovr = 1; cyc(); strobes_off(); err_en = 0;

      // R9 soft reset
      in_valid = 1; in_data = 16'h0009; cyc(); strobes_off();
      soft_rst = 1; flt_valid = 1; cyc(); strobes_off();
      check("R9 buffer cleared", {15'd0, fifo_valid}, 16'd0);
      check("R9 data zeroed", host_data, 16'd0);
      check("R9 flag cleared", {15'd0, rdy_flag}, 16'd0);
      fifo_ready = 1; cyc(); fifo_ready = 0;
      check("R9 hold cleared", {15'd0, fifo_valid}, 16'd0);
      bypass = 0;

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         if (i % 50 == 0) begin
            bypass = ($urandom % 3) == 0; dest_host = $urandom % 2;
            prefill = ($urandom % 4) == 0; dma_sel = $urandom % 2;
            buf_ie = $urandom % 2; err_en = $urandom % 2;
         end
         soft_rst   = ($urandom % 64) == 0;
         flt_valid  = ($urandom % 3) == 0;
         flt_data   = DW'($urandom);
         in_valid   = ($urandom % 3) == 0;
         in_data    = DW'($urandom);
         fifo_ready = ($urandom % 2) == 0;
         host_rd    = ($urandom % 3) == 0;
         clr_rdy    = ($urandom % 4) == 0;
         clr_ovr    = ($urandom % 8) == 0;
         clr_iovr   = ($urandom % 8) == 0;
         dma_ack    = ($urandom % 5) == 0;
         cyc();
      end
      strobes_off();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule